// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Buffer

This block is the sending half of an asynchronous serial port. Software writes a character into a holding register with a single-cycle strobe. At the next baud tick, if the shifter is free, the held character is moved into the shift register. The character then leaves on the serial line: a low start bit, the data bits with the least significant first, an optional parity bit, and one or two high stop bits. Each bit lasts exactly one period of the externally supplied baud tick.

Framing is set by live control inputs, which are read at the moment of transfer. A two-bit length code chooses 7, 8 or 9 data bits, or a loopback mode. In loopback mode a 9-bit frame goes to an internal loop output instead of the pin. One control input does two jobs. In 9-bit frames it is the ninth data bit. In 7-bit and 8-bit frames it is the low half of the parity selector. A break input forces the line low for as long as software holds it.

Status outputs report an empty holding register and an active frame. The interrupt request is the empty flag gated by an enable input. A character written while a frame is on the line is sent straight after that frame's last stop bit, with no idle bit in between.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, `txd` and `loop_out` are high, `buf_empty` is 1, `busy` is 0 and `irq` is 0.
- R2: A frame starts at the first baud tick on which a character is held and the shifter is free. The line then carries a low start bit, the data bits least significant first, the parity bit if enabled, and the stop bits high. Each bit is held from one tick to the next.
- R3: `len_sel` chooses the data width: 2'b00 gives 8 bits, 2'b01 gives 7 bits, 2'b10 gives 9 bits with the ninth bit taken from `bit9_psel`, and 2'b11 is loopback with the same 9-bit format.
- R4: In 7-bit and 8-bit frames the parity code {`psel_hi`, `bit9_psel`} selects the parity mode. 2'b01 is odd, 2'b10 is even, and 2'b00 and 2'b11 mean no parity. The parity bit follows the last data bit. 9-bit and loopback frames never carry parity, whatever `psel_hi` is set to.
- R5: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two.
- R6: While `brk` is 1, `txd` is low, whatever the transmitter's state.
- R7: `buf_empty` reads 0 in the cycle after a write strobe. It returns to 1 on the clock edge where the held character moves into the shifter, which is the same edge on which `busy` rises.
- R8: `busy` is 1 for the whole frame. It falls on the tick that ends the last stop bit when no character is waiting, and the line is then high.
- R9: A character written during a frame starts on the tick that ends that frame's last stop bit, with no idle bit between the two frames.
- R10: `irq` is 1 exactly when `buf_empty` is 1 and `irq_en` is 1.
- R11: In loopback mode the frame appears on `loop_out` and `txd` stays high. In the other modes `loop_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_stb | input | 1 | Write strobe that loads the holding register |
| wr_data | input | 8 | Character low eight bits |
| len_sel | input | 2 | Length code: 00=8, 01=7, 10=9, 11=loopback |
| bit9_psel | input | 1 | Ninth data bit, or low parity-select bit |
| psel_hi | input | 1 | High parity-select bit |
| two_stop | input | 1 | 1 selects two stop bits |
| brk | input | 1 | Forces `txd` low |
| irq_en | input | 1 | Transmit interrupt enable |
| txd | output | 1 | Serial line, idles high |
| loop_out | output | 1 | Loopback serial stream, idles high |
| buf_empty | output | 1 | Holding register empty |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse. They also assume that the framing controls stay steady from a write until the matching `busy` rise, because the frame is built from them on that edge. The bench meets both conditions. Its tick generator pulses one cycle in five. It changes the length, parity and stop controls only while nothing is held and no frame is active. For the chained case it writes the second character during the first frame without touching the configuration.

// File: rtl/txs_pkg.sv
package txs_pkg;
    localparam int DATA_MAX  = 9;
    localparam int STOP_MAX  = 2;
    localparam int FRAME_MAX = 1 + DATA_MAX + STOP_MAX;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        LEN_8    = 2'b00,
        LEN_7    = 2'b01,
        LEN_9    = 2'b10,
        LEN_LOOP = 2'b11
    } len_code_e;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [CNT_W-1:0]     nbits;
        logic                 loop;
    } frame_t;
endpackage

// File: rtl/txs_frame_build.sv
module txs_frame_build
    import txs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] data,
    input  logic [1:0]        len_sel,
    input  logic              bit9_psel,
    input  logic              psel_hi,
    input  logic              two_stop,
    output frame_t            frm
);
    int         dn;
    logic [1:0] psel;
    logic       par_on;
    logic       par_bit;
    logic [BYTE_W-1:0] masked;

    always_comb begin
        case (len_code_e'(len_sel))
            LEN_7:   dn = 7;
            LEN_8:   dn = 8;
            default: dn = 9;
        endcase
        psel   = {psel_hi, bit9_psel};
        par_on = (dn < 9) && (psel == 2'b01 || psel == 2'b10);
        masked = (dn == 7) ? (data & {1'b0, {(BYTE_W-1){1'b1}}}) : data;
        // even: make total ones even; odd: make it odd
        par_bit = (^masked) ^ (psel == 2'b01);

        frm.bits    = '1;
        frm.bits[0] = 1'b0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < dn) frm.bits[1+i] = data[i];
        end
        if (dn == 9) frm.bits[9] = bit9_psel;
        if (par_on)  frm.bits[1+dn] = par_bit;
        frm.nbits = CNT_W'(1 + dn + (par_on ? 1 : 0) + (two_stop ? 2 : 1));
        frm.loop  = (len_code_e'(len_sel) == LEN_LOOP);
    end
endmodule

// File: rtl/txs_hold_buf.sv
module txs_hold_buf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    output logic [BYTE_W-1:0] hold_data,
    output logic              full
);
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              full;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take)   h_d.full = 1'b0;
        if (wr_stb) begin
            h_d.data = wr_data;
            h_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign hold_data = h_q.data;
    assign full      = h_q.full;
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
    import txs_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        len_sel,
    input  logic              bit9_psel,
    input  logic              psel_hi,
    input  logic              two_stop,
    input  logic              brk,
    input  logic              irq_en,
    output logic              txd,
    output logic              loop_out,
    output logic              buf_empty,
    output logic              busy,
    output logic              irq
);
    typedef struct packed {
        logic                 busy;
        logic                 loop;
        logic [FRAME_MAX-1:0] shift;
        logic [CNT_W-1:0]     cnt;
    } shf_t;

    shf_t   s_d, s_q;
    frame_t frm;
    logic   [BYTE_W-1:0] hold_data;
    logic   hold_full;
    logic   last_bit;
    logic   load;

    txs_hold_buf #(.BYTE_W(BYTE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .take      (load),
        .hold_data (hold_data),
        .full      (hold_full)
    );

    txs_frame_build #(.BYTE_W(BYTE_W)) u_build (
        .data      (hold_data),
        .len_sel   (len_sel),
        .bit9_psel (bit9_psel),
        .psel_hi   (psel_hi),
        .two_stop  (two_stop),
        .frm       (frm)
    );

    assign last_bit = s_q.busy && (s_q.cnt == CNT_W'(1));
    assign load     = baud_tick && hold_full && (!s_q.busy || last_bit);

    always_comb begin
        s_d = s_q;
        if (baud_tick && s_q.busy) begin
            if (last_bit) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.shift = {1'b1, s_q.shift[FRAME_MAX-1:1]};
                s_d.cnt   = s_q.cnt - CNT_W'(1);
            end
        end
        if (load) begin
            s_d.busy  = 1'b1;
            s_d.loop  = frm.loop;
            s_d.shift = frm.bits;
            s_d.cnt   = frm.nbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, loop: 1'b0, shift: '1, cnt: '0};
        else        s_q <= s_d;
    end

    assign txd       = brk ? 1'b0 : ((s_q.busy && !s_q.loop) ? s_q.shift[0] : 1'b1);
    assign loop_out  = (s_q.busy && s_q.loop) ? s_q.shift[0] : 1'b1;
    assign buf_empty = !hold_full;
    assign busy      = s_q.busy;
    assign irq       = buf_empty && irq_en;
endmodule

// File: rtl/serial_tx_engine_chk.sv
module serial_tx_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       wr_stb,
    input logic [7:0] wr_data,
    input logic [1:0] len_sel,
    input logic       bit9_psel,
    input logic       psel_hi,
    input logic       two_stop,
    input logic       brk,
    input logic       irq_en,
    input logic       txd,
    input logic       loop_out,
    input logic       buf_empty,
    input logic       busy,
    input logic       irq
);
    a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !txd);
    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !buf_empty);
    a_r7_start_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (buf_empty || $past(wr_stb)));
    a_r8_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(baud_tick));
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !brk) |-> (txd && loop_out));
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    a_r11_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_out |-> txd || brk);
endmodule

bind serial_tx_engine serial_tx_engine_chk u_chk (.*);

// File: tb/serial_tx_engine_bench.sv
module serial_tx_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_sel = 2'b00;
    logic bit9_psel = 1'b0, psel_hi = 1'b0, two_stop = 1'b0, brk = 1'b0, irq_en = 1'b0;
    logic txd, loop_out, buf_empty, busy, irq;

    always #5 clk = ~clk;

    serial_tx_engine u_serial_tx_engine (.*);

    typedef struct {
        logic [11:0] bits;
        int          n;
        bit          loop;
        bit          chain;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int checks = 0, fails = 0;
    bit in_frame = 0, post_pending = 0, expect_chain = 0, mon_en = 1;
    int idx = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t build_exp(input logic [7:0] d, input bit chain, input string tag);
        exp_t e;
        int dn, p;
        bit par_on, par;
        dn = (len_sel == 2'b01) ? 7 : (len_sel == 2'b00) ? 8 : 9;
        e.bits = '1;
        e.bits[0] = 1'b0;
        p = 1;
        par = 1'b0;
        for (int i = 0; i < dn; i++) begin
            e.bits[p] = (i == 8) ? bit9_psel : d[i];
            if (i < 8) par ^= d[i];
            p++;
        end
        par_on = (dn < 9) && ({psel_hi, bit9_psel} == 2'b01 || {psel_hi, bit9_psel} == 2'b10);
        if (par_on) begin
            e.bits[p] = ({psel_hi, bit9_psel} == 2'b01) ? ~par : par;
            p++;
        end
        e.n = p + (two_stop ? 2 : 1);
        e.loop = (len_sel == 2'b11);
        e.chain = chain;
        e.tag = tag;
        return e;
    endfunction

    task automatic sample();
        logic line;
        if (!mon_en) return;
        if (post_pending) begin
            post_pending = 0;
            chk(busy == 1'b0, "R8 busy after last stop", busy, 0);
            chk(txd == 1'b1, "R8 line high after frame", txd, 1);
        end
        if (!in_frame && q.size() > 0) begin
            line = q[0].loop ? loop_out : txd;
            if (line == 1'b0) begin
                cur = q.pop_front();
                in_frame = 1;
                idx = 0;
            end else if (expect_chain) begin
                chk(0, "R9 no gap before chained frame", line, 0);
            end
        end
        expect_chain = 0;
        if (in_frame) begin
            line = cur.loop ? loop_out : txd;
            chk(line == cur.bits[idx], cur.tag, int'(line), int'(cur.bits[idx]));
            chk(busy == 1'b1, "R8 busy during frame", busy, 1);
            if (cur.loop) chk(txd == 1'b1, "R11 txd high in loopback", txd, 1);
            else          chk(loop_out == 1'b1, "R11 loop_out idle", loop_out, 1);
            idx++;
            if (idx == cur.n) begin
                in_frame = 0;
                if (q.size() > 0 && q[0].chain) expect_chain = 1;
                else                            post_pending = 1;
            end
        end
    endtask

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (baud_tick) sample();
            ph++;
            baud_tick = (ph % 5 == 0);
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic write_char(input logic [7:0] d, input bit chain, input string tag);
        q.push_back(build_exp(d, chain, tag));
        @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(buf_empty == 1'b0, "R7 empty clears after write", buf_empty, 0);
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (busy || !buf_empty || q.size() > 0 || in_frame || post_pending);
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        write_char(d, 1'b0, tag);
        if (!busy) begin
            do @(negedge clk); while (!busy);
            chk(buf_empty == 1'b1, "R7 empty set on transfer", buf_empty, 1);
        end
        wait_idle();
    endtask

    task automatic cfg(input logic [1:0] l, input bit b9, input bit ph, input bit ts);
        len_sel = l; bit9_psel = b9; psel_hi = ph; two_stop = ts;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(loop_out == 1'b1, "R1 loop_out", loop_out, 1);
        chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R10 irq when empty and enabled", irq, 1);

        cfg(2'b00, 0, 0, 0);
        q.push_back(build_exp(8'hA5, 1'b0, "R2 8-bit no parity"));
        @(negedge clk); wr_stb = 1'b1; wr_data = 8'hA5;
        @(negedge clk); wr_stb = 1'b0;
        chk(irq == 1'b0, "R10 irq low while full", irq, 0);
        do @(negedge clk); while (!busy);
        chk(buf_empty == 1'b1, "R7 empty set on transfer", buf_empty, 1);
        wait_idle();

        cfg(2'b01, 1, 0, 1); send(8'h53, "R4 7-bit odd two stop R5");
        cfg(2'b01, 0, 1, 0); send(8'hD3, "R4 7-bit even, bit7 ignored");
        cfg(2'b00, 1, 0, 0); send(8'h6E, "R4 8-bit odd");
        cfg(2'b00, 0, 1, 1); send(8'h81, "R4 8-bit even R5 two stop");
        cfg(2'b00, 1, 1, 0); send(8'h7F, "R4 code 11 no parity");
        cfg(2'b10, 1, 1, 0); send(8'h0F, "R3 9-bit ninth=1 no parity");
        cfg(2'b10, 0, 0, 1); send(8'hF0, "R3 9-bit ninth=0");

        cfg(2'b00, 0, 0, 0);
        write_char(8'h3C, 1'b0, "R9 first of chain");
        do @(negedge clk); while (!busy);
        write_char(8'hC3, 1'b1, "R9 chained frame");
        wait_idle();

        cfg(2'b11, 1, 0, 0); send(8'h81, "R11 loopback frame R3");

        cfg(2'b00, 0, 0, 0);
        mon_en = 0;
        brk = 1'b1;
        repeat (12) begin
            @(negedge clk);
            chk(txd == 1'b0, "R6 break holds low", txd, 0);
        end
        brk = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R6 release returns high", txd, 1);
        mon_en = 1;

        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R2 all frames seen", q.size(), 0);
        finish_run();
    end
endmodule